// File: doc/BRIEF.md
# Run-Time Configurable Byte Substitution Engine

This block replaces one byte by another through a substitution whose algebra is set at run time rather than fixed in gates. A configuration carries three items: the low eight coefficients of a degree-8 field polynomial, an 8x8 binary matrix and an 8-bit offset. For an input byte the engine forms the multiplicative inverse in the chosen field, multiplies that inverse as a bit vector by the matrix, and adds the offset with XOR. The inverse is computed by raising the byte to the power 254 with a one-bit-per-cycle field multiplier and square-and-multiply, so a zero byte enters the affine step as zero.

Lookups use a request/acknowledge pair: the requester holds `reqValid` with a byte on `reqByte` until `ack` pulses for one cycle with the result on `ackByte`. Loading a new configuration starts a validation sweep that runs every one of the 256 input bytes through the same datapath. The sweep reports the configuration good on `cfgOk` only when no byte maps to itself or to its bitwise complement and the matrix has full rank, found by Gaussian elimination over GF(2). Lookups wait while the sweep runs. After reset the engine holds a standard configuration: polynomial x^8+x^4+x^3+x+1, the circulant matrix of the common cipher S-box, and offset 0x63.

Top module: `sbox_engine`

## Requirements
- R1: After reset `ack`, `cfgBusy` and `cfgOk` are low, and the active configuration is polynomial 0x11B, matrix rows (row 7 down to row 0) F8 7C 3E 1F 8F C7 E3 F1, offset 0x63.
- R2: With the reset configuration a lookup of 0x00 returns 0x63 and a lookup of 0x01 returns 0x7C.
- R3: A lookup of x returns M·inv(x) XOR c. inv is x^254 in GF(2)[t] modulo t^8 + `cfgPoly` (bit i of `cfgPoly` is the coefficient of t^i), so inv(0)=0. Bits [8r+7:8r] of `cfgMatrix` hold matrix row r, and result bit r is the parity of row r ANDed with inv(x).
- R4: `ack` is high for exactly one cycle per lookup, and a request still high during that cycle does not start another lookup.
- R5: `cfgLoad` seen while the engine is idle captures the configuration, raises `cfgBusy` on the next cycle and clears `cfgOk`.
- R6: While `cfgBusy` is high no lookup is served and `ack` stays low; a pending request is served after the sweep ends.
- R7: The sweep covers all 256 inputs. Afterwards `cfgOk` is 1 only if no x has S(x)=x or S(x)=~x and the matrix is invertible over GF(2); while the sweep runs `cfgOk` reads 0.
- R8: `cfgLoad` asserted while a sweep or lookup is in progress is ignored, and the active configuration is left unchanged.
- R9: When `cfgLoad` and `reqValid` are both high in an idle cycle, the configuration load is taken first.
- R10: `ackByte` holds its value between acknowledge pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Load configuration and start the validation sweep |
| cfgPoly | input | 8 | Field polynomial coefficients t^7..t^0 (t^8 implied) |
| cfgMatrix | input | 64 | Affine matrix, row r in bits [8r+7:8r] |
| cfgConst | input | 8 | Offset XORed after the matrix product |
| cfgBusy | output | 1 | Validation sweep running |
| cfgOk | output | 1 | Last sweep found a valid configuration |
| reqValid | input | 1 | Lookup request, held until ack |
| reqByte | input | 8 | Byte to substitute |
| ack | output | 1 | One-cycle pulse: result valid |
| ackByte | output | 8 | Substituted byte |

## Verification
The bench builds the engine with its default parameters, so the reset configuration is the standard cipher field, matrix and offset. This makes the known values for 0x00 and 0x01 reachable right after reset, with no load. Other field polynomials, an offset that creates a fixed point, and a singular matrix are reached through run-time loads, and each loaded configuration costs one full 256-input sweep. A second load during a sweep, and a request pending alongside a load, cover the ordering rules.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  localparam int SB_W       = 8;
  localparam int SB_VALUES  = 1 << SB_W;
  localparam int SB_MAT_W   = SB_W * SB_W;
  // x^(2^W-2): MSB-first square-and-multiply starting from acc = x
  localparam int SB_NUM_OPS = 2 * SB_W - 3;
  localparam int SB_OP_W    = $clog2(SB_NUM_OPS);
  localparam int SB_CNT_W   = $clog2(SB_W);

  typedef logic [SB_W-1:0] sbByte_t;

  typedef struct packed {
    logic    loadCfg;
    logic    loadX;
    sbByte_t xVal;
    logic    mulStart;
    logic    mulSquare;
  } dpCmd_t;

  // multiply by t, reduce with the implied t^W term
  function automatic sbByte_t sbXtime(sbByte_t v, sbByte_t poly);
    sbByte_t res;
    res = {v[SB_W-2:0], 1'b0};
    if (v[SB_W-1]) res = res ^ poly;
    return res;
  endfunction

  // full-rank test by elimination over GF(2)
  function automatic logic sbRankFull(logic [SB_MAT_W-1:0] m);
    logic [SB_W-1:0][SB_W-1:0] rows;
    logic [SB_W-1:0] used;
    logic found;
    logic full;
    int   piv;
    rows = m;
    used = '0;
    full = 1'b1;
    for (int c = 0; c < SB_W; c++) begin
      found = 1'b0;
      piv   = 0;
      for (int r = 0; r < SB_W; r++) begin
        if (!found && !used[r] && rows[r][c]) begin
          found = 1'b1;
          piv   = r;
        end
      end
      if (!found) begin
        full = 1'b0;
      end else begin
        used[piv] = 1'b1;
        for (int r = 0; r < SB_W; r++) begin
          if (r != piv && rows[r][c]) rows[r] = rows[r] ^ rows[piv];
        end
      end
    end
    return full;
  endfunction

endpackage

// File: rtl/sbox_datapath.sv
module sbox_datapath
  import sbox_pkg::*;
#(
  parameter sbByte_t               DEF_POLY   = 8'h1B,
  parameter logic [SB_MAT_W-1:0]   DEF_MATRIX = 64'hF87C3E1F8FC7E3F1,
  parameter sbByte_t               DEF_CONST  = 8'h63
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  input  sbByte_t             cfgPoly,
  input  logic [SB_MAT_W-1:0] cfgMatrix,
  input  sbByte_t             cfgConst,
  output logic                mulDone,
  output sbByte_t             sOut,
  output logic                rankFull
);

  sbByte_t             polyR;
  logic [SB_MAT_W-1:0] matR;
  sbByte_t             constR;
  sbByte_t             xR;
  sbByte_t             accR;
  sbByte_t             opA;
  sbByte_t             opB;
  sbByte_t             part;
  sbByte_t             partNext;
  logic [SB_CNT_W-1:0] cnt;
  logic                busy;
  logic                doneR;
  logic                rankR;
  sbByte_t             prodRaw;

  // one multiplier bit per cycle, most significant bit of opB first
  assign partNext = sbXtime(part, polyR) ^ (opB[cnt] ? opA : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polyR  <= DEF_POLY;
      matR   <= DEF_MATRIX;
      constR <= DEF_CONST;
      rankR  <= sbRankFull(DEF_MATRIX);
      xR     <= '0;
      accR   <= '0;
      opA    <= '0;
      opB    <= '0;
      part   <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      doneR  <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (cmd.loadCfg) begin
        polyR  <= cfgPoly;
        matR   <= cfgMatrix;
        constR <= cfgConst;
        rankR  <= sbRankFull(cfgMatrix);
      end
      if (cmd.loadX) begin
        xR   <= cmd.xVal;
        accR <= cmd.xVal;
      end
      if (cmd.mulStart) begin
        opA  <= accR;
        opB  <= cmd.mulSquare ? accR : xR;
        part <= '0;
        cnt  <= SB_CNT_W'(SB_W - 1);
        busy <= 1'b1;
      end else if (busy) begin
        part <= partNext;
        cnt  <= cnt - 1'b1;
        if (cnt == '0) begin
          accR  <= partNext;
          busy  <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  // affine step: one parity tree per output bit
  for (genvar r = 0; r < SB_W; r++) begin : gAffineRow
    assign prodRaw[r] = ^(matR[r*SB_W +: SB_W] & accR);
  end

  assign sOut     = prodRaw ^ constR;
  assign mulDone  = doneR;
  assign rankFull = rankR;

endmodule

// File: rtl/sbox_ctrl.sv
module sbox_ctrl
  import sbox_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgLoad,
  input  logic    reqValid,
  input  sbByte_t reqByte,
  input  logic    mulDone,
  input  sbByte_t sOut,
  input  logic    rankFull,
  output dpCmd_t  cmd,
  output logic    cfgBusy,
  output logic    cfgOk,
  output logic    ack,
  output sbByte_t ackByte
);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT, ST_FINISH} ctrlState_t;

  localparam logic [SB_OP_W-1:0] LAST_OP = SB_OP_W'(SB_NUM_OPS - 1);

  ctrlState_t         state, stateN;
  logic [SB_OP_W-1:0] opIdx, opN;
  sbByte_t            sweepIdx, idxN;
  logic               sweeping, sweepN;
  logic               bad, badN;
  logic               okR, okN;
  logic               ackR, ackN;
  sbByte_t            byteR, byteN;
  logic               hit;

  assign hit = (sOut == sweepIdx) || (sOut == ~sweepIdx);

  always_comb begin
    cmd    = '0;
    stateN = state;
    opN    = opIdx;
    idxN   = sweepIdx;
    sweepN = sweeping;
    badN   = bad;
    okN    = okR;
    ackN   = 1'b0;
    byteN  = byteR;
    case (state)
      ST_IDLE: begin
        if (cfgLoad) begin
          cmd.loadCfg = 1'b1;
          cmd.loadX   = 1'b1;
          cmd.xVal    = '0;
          idxN        = '0;
          sweepN      = 1'b1;
          badN        = 1'b0;
          okN         = 1'b0;
          stateN      = ST_START;
        end else if (reqValid && !ackR) begin
          cmd.loadX = 1'b1;
          cmd.xVal  = reqByte;
          stateN    = ST_START;
        end
      end
      ST_START: begin
        cmd.mulStart  = 1'b1;
        cmd.mulSquare = 1'b1;
        opN           = '0;
        stateN        = ST_WAIT;
      end
      ST_WAIT: begin
        if (mulDone) begin
          if (opIdx == LAST_OP) begin
            stateN = ST_FINISH;
          end else begin
            cmd.mulStart  = 1'b1;
            cmd.mulSquare = opIdx[0];
            opN           = opIdx + 1'b1;
          end
        end
      end
      ST_FINISH: begin
        if (sweeping) begin
          badN = bad | hit;
          if (sweepIdx == '1) begin
            sweepN = 1'b0;
            okN    = rankFull && !(bad || hit);
            stateN = ST_IDLE;
          end else begin
            idxN      = sweepIdx + 1'b1;
            cmd.loadX = 1'b1;
            cmd.xVal  = sweepIdx + 1'b1;
            stateN    = ST_START;
          end
        end else begin
          ackN   = 1'b1;
          byteN  = sOut;
          stateN = ST_IDLE;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      opIdx    <= '0;
      sweepIdx <= '0;
      sweeping <= 1'b0;
      bad      <= 1'b0;
      okR      <= 1'b0;
      ackR     <= 1'b0;
      byteR    <= '0;
    end else begin
      state    <= stateN;
      opIdx    <= opN;
      sweepIdx <= idxN;
      sweeping <= sweepN;
      bad      <= badN;
      okR      <= okN;
      ackR     <= ackN;
      byteR    <= byteN;
    end
  end

  assign cfgBusy = sweeping;
  assign cfgOk   = okR;
  assign ack     = ackR;
  assign ackByte = byteR;

endmodule

// File: rtl/sbox_engine.sv
module sbox_engine
  import sbox_pkg::*;
#(
  parameter logic [SB_W-1:0]     DEF_POLY   = 8'h1B,
  parameter logic [SB_MAT_W-1:0] DEF_MATRIX = 64'hF87C3E1F8FC7E3F1,
  parameter logic [SB_W-1:0]     DEF_CONST  = 8'h63
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgLoad,
  input  logic [SB_W-1:0]     cfgPoly,
  input  logic [SB_MAT_W-1:0] cfgMatrix,
  input  logic [SB_W-1:0]     cfgConst,
  output logic                cfgBusy,
  output logic                cfgOk,
  input  logic                reqValid,
  input  logic [SB_W-1:0]     reqByte,
  output logic                ack,
  output logic [SB_W-1:0]     ackByte
);

  dpCmd_t  cmd;
  logic    mulDone;
  logic    rankFull;
  sbByte_t sOut;

  sbox_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgLoad  (cfgLoad),
    .reqValid (reqValid),
    .reqByte  (reqByte),
    .mulDone  (mulDone),
    .sOut     (sOut),
    .rankFull (rankFull),
    .cmd      (cmd),
    .cfgBusy  (cfgBusy),
    .cfgOk    (cfgOk),
    .ack      (ack),
    .ackByte  (ackByte)
  );

  sbox_datapath #(
    .DEF_POLY   (DEF_POLY),
    .DEF_MATRIX (DEF_MATRIX),
    .DEF_CONST  (DEF_CONST)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .cfgPoly   (cfgPoly),
    .cfgMatrix (cfgMatrix),
    .cfgConst  (cfgConst),
    .mulDone   (mulDone),
    .sOut      (sOut),
    .rankFull  (rankFull)
  );

endmodule

// File: rtl/sbox_engine_chk.sv
module sbox_engine_chk
  import sbox_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            cfgLoad,
  input logic            cfgBusy,
  input logic            cfgOk,
  input logic            ack,
  input logic [SB_W-1:0] ackByte
);

  logic [15:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (cfgBusy) busyCnt <= (busyCnt == 16'hFFFF) ? busyCnt : busyCnt + 1'b1;
    else busyCnt <= '0;
  end

  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  assert_busy_from_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgBusy) |-> $past(cfgLoad));

  assert_no_ack_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgBusy |-> !ack);

  assert_ok_hidden_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgBusy |-> !cfgOk);

  assert_sweep_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgBusy) |-> busyCnt >= 16'(SB_VALUES));

  assert_hold_byte_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ack |-> $stable(ackByte));

endmodule

bind sbox_engine sbox_engine_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgLoad (cfgLoad),
  .cfgBusy (cfgBusy),
  .cfgOk   (cfgOk),
  .ack     (ack),
  .ackByte (ackByte)
);

// File: tb/tb_sbox_engine.sv
module tb_sbox_engine;

  localparam logic [63:0] AES_MAT = 64'hF87C3E1F8FC7E3F1;
  localparam logic [63:0] ID_MAT  = 64'h8040201008040201;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [7:0]  cfgPoly = 8'h1B;
  logic [63:0] cfgMatrix = AES_MAT;
  logic [7:0]  cfgConst = 8'h63;
  logic        cfgBusy, cfgOk;
  logic        reqValid = 1'b0;
  logic [7:0]  reqByte = 8'h00;
  logic        ack;
  logic [7:0]  ackByte;

  int errors = 0;
  int checks = 0;
  bit doneFlag = 1'b0;

  logic [7:0]  curPoly = 8'h1B;
  logic [63:0] curMat  = AES_MAT;
  logic [7:0]  curConst = 8'h63;

  always #5 clk = ~clk;

  sbox_engine dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgPoly(cfgPoly),
    .cfgMatrix(cfgMatrix), .cfgConst(cfgConst), .cfgBusy(cfgBusy),
    .cfgOk(cfgOk), .reqValid(reqValid), .reqByte(reqByte),
    .ack(ack), .ackByte(ackByte)
  );

  // reference field arithmetic, least significant bit first
  function automatic logic [7:0] mMul(logic [7:0] a, logic [7:0] b, logic [7:0] p);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ a;
      a = a[7] ? ((a << 1) ^ p) : (a << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] mLin(logic [7:0] v, logic [63:0] m);
    logic [7:0] o;
    for (int r = 0; r < 8; r++) o[r] = ^(m[8*r +: 8] & v);
    return o;
  endfunction

  function automatic logic [7:0] mSub(logic [7:0] x, logic [7:0] p, logic [63:0] m, logic [7:0] c);
    logic [7:0] v = (x == 8'h00) ? 8'h00 : 8'h01;
    if (x != 8'h00) for (int k = 0; k < 254; k++) v = mMul(v, x, p);
    return mLin(v, m) ^ c;
  endfunction

  function automatic bit mOk(logic [7:0] p, logic [63:0] m, logic [7:0] c);
    logic [7:0] s;
    for (int x = 0; x < 256; x++) begin
      s = mSub(8'(x), p, m, c);
      if (s == 8'(x) || s == ~8'(x)) return 1'b0;
    end
    for (int v = 1; v < 256; v++) if (mLin(8'(v), m) == 8'h00) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [7:0] x, output logic [7:0] res);
    @(negedge clk);
    reqValid = 1'b1;
    reqByte  = x;
    do @(negedge clk); while (!ack);
    res = ackByte;
    reqValid = 1'b0;
  endtask

  task automatic loadCfg(input logic [7:0] p, input logic [63:0] m, input logic [7:0] c);
    bit expOk;
    @(negedge clk);
    cfgLoad = 1'b1; cfgPoly = p; cfgMatrix = m; cfgConst = c;
    @(negedge clk);
    cfgLoad = 1'b0;
    check("R5 busy after load", 64'(cfgBusy), 64'd1);
    check("R5 ok cleared", 64'(cfgOk), 64'd0);
    curPoly = p; curMat = m; curConst = c;
    expOk = mOk(p, m, c);
    while (cfgBusy) @(negedge clk);
    check("R7 validation verdict", 64'(cfgOk), 64'(expOk));
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!doneFlag) begin
      errors++;
      $display("FAIL R4 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, hold, x;
    int ackBusy;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ack at reset", 64'(ack), 64'd0);
    check("R1 busy at reset", 64'(cfgBusy), 64'd0);
    check("R1 ok at reset", 64'(cfgOk), 64'd0);

    lookup(8'h00, r); check("R2 S(00)", 64'(r), 64'h63);
    lookup(8'h01, r); check("R2 S(01)", 64'(r), 64'h7C);
    check("R1 default config S(53)", 64'(mSub(8'h53, 8'h1B, AES_MAT, 8'h63)), 64'hED);

    @(negedge clk);
    check("R4 ack single cycle", 64'(ack), 64'd0);
    hold = ackByte;
    repeat (5) @(negedge clk);
    check("R10 ackByte held", 64'(ackByte), 64'(hold));

    for (int i = 0; i < 12; i++) begin
      x = 8'($urandom);
      lookup(x, r);
      check("R3 random lookup default", 64'(r), 64'(mSub(x, curPoly, curMat, curConst)));
    end
    lookup(8'hFF, r);
    check("R3 lookup FF", 64'(r), 64'(mSub(8'hFF, curPoly, curMat, curConst)));

    // load and request together, second load during the sweep
    @(negedge clk);
    cfgLoad = 1'b1; cfgPoly = 8'h1B; cfgMatrix = AES_MAT; cfgConst = 8'h63;
    reqValid = 1'b1; reqByte = 8'h53;
    @(negedge clk);
    cfgLoad = 1'b0;
    check("R9 load taken first", 64'(cfgBusy), 64'd1);
    check("R5 ok cleared", 64'(cfgOk), 64'd0);
    ackBusy = 0;
    repeat (1000) begin
      if (ack) ackBusy++;
      @(negedge clk);
    end
    cfgLoad = 1'b1; cfgPoly = 8'h1B; cfgMatrix = ID_MAT; cfgConst = 8'h00;
    @(negedge clk);
    cfgLoad = 1'b0;
    while (cfgBusy) begin
      if (ack) ackBusy++;
      @(negedge clk);
    end
    check("R6 no ack during sweep", 64'(ackBusy), 64'd0);
    check("R7 default config valid", 64'(cfgOk), 64'd1);
    while (!ack) @(negedge clk);
    r = ackByte;
    reqValid = 1'b0;
    check("R8 ignored load kept config", 64'(r), 64'hED);
    check("R6 pending request served", 64'(r), 64'(mSub(8'h53, 8'h1B, AES_MAT, 8'h63)));

    // offset zero gives S(0)=0: rejected
    loadCfg(8'h1B, AES_MAT, 8'h00);
    check("R7 fixed point rejects", 64'(cfgOk), 64'd0);
    lookup(8'h00, r);
    check("R3 zero maps through affine", 64'(r), 64'h00);
    for (int i = 0; i < 3; i++) begin
      x = 8'($urandom);
      lookup(x, r);
      check("R3 lookup offset zero", 64'(r), 64'(mSub(x, curPoly, curMat, curConst)));
    end

    // other field polynomial
    loadCfg(8'h1D, AES_MAT, 8'h63);
    for (int i = 0; i < 4; i++) begin
      x = 8'($urandom);
      lookup(x, r);
      check("R3 lookup poly 11D", 64'(r), 64'(mSub(x, curPoly, curMat, curConst)));
    end

    // singular matrix: rows 3 and 5 equal
    begin
      logic [63:0] m;
      m = {$urandom, $urandom};
      m[8*5 +: 8] = m[8*3 +: 8];
      loadCfg(8'h1B, m, 8'($urandom));
      check("R7 singular matrix rejects", 64'(cfgOk), 64'd0);
    end
    for (int i = 0; i < 4; i++) begin
      x = 8'($urandom);
      lookup(x, r);
      check("R3 lookup random matrix", 64'(r), 64'(mSub(x, curPoly, curMat, curConst)));
    end

    doneFlag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule